// File: doc/BRIEF.md
# Suspend-to-RAM Entry Sequencer

This block is the power-management controller on the I/O-hub side that walks a platform into suspend-to-RAM and back out again. Software starts it with one register write that carries an enable bit and a sleep-type code. The sequencer then pulls the active-low stop-clock line to the processors and waits for a decoded stop-grant bus cycle. That cycle arrives as a one-cycle strobe. Once the grant is in, it raises the stop-control output, waits a fixed number of cycles, and then raises the platform reset that tells downstream logic to gate its I/O.

If no grant arrives within a programmable window, the attempt is abandoned. Stop-clock is released, the machine returns to idle and a sticky error bit is set. A wake input takes the platform back out in reverse order: reset falls first, then stop-control, then stop-clock. The current state encoding and the error bit are visible at all times on plain read-only status pins. All pins are level or strobe control signals, so no valid/ready handshake exists at the edge.

Top module: `slp_seq_top`

## Requirements
- R1: After reset, sts_state is 0 (idle), stop_clk_n is 1, stop_ctl is 0, plat_rst is 0 and sts_err is 0.
- R2: A start is a cycle with cmd_we=1, cmd_en=1 and cmd_type equal to SUSP_CODE (default 3'b101). A start sampled in idle moves sts_state to 1 (stop-clock wait), drives stop_clk_n to 0 and clears sts_err, all from the next cycle. A write with cmd_en=0, a write with another type code, and any write outside idle leave state and pins unchanged.
- R3: stpgnt_strb has no effect in any state other than 1.
- R4: A stpgnt_strb in one of the first Weff cycles of state 1 moves sts_state to 2 and raises stop_ctl on the next cycle. Weff equals tmo_win, or 1 when tmo_win is 0. The strobe is counted from the first cycle in which stop_clk_n is low.
- R5: stop_ctl stays high with plat_rst low for exactly ENTRY_DLY cycles in state 2. Then plat_rst rises in state 3 for one cycle, and the machine moves to state 4 (sleeping) with all three controls asserted.
- R6: If no grant arrives in the Weff cycles of state 1, the next cycle shows sts_state 0, stop_clk_n 1 and sts_err 1. A grant in the last cycle of the window takes priority over the timeout.
- R7: State 4 is held for as long as wake stays 0. wake has no effect outside state 4.
- R8: wake in state 4 moves to state 5 (resuming). For WAKE_GAP cycles plat_rst is 0 while stop_ctl stays 1 and stop_clk_n stays 0. For the next WAKE_GAP cycles stop_ctl is also 0. The machine then returns to state 0 with stop_clk_n at 1.
- R9: sts_state uses the encoding 0 idle, 1 stop-clock wait, 2 stop-control, 3 reset, 4 sleeping, 5 resuming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe of the sleep command register |
| cmd_en | input | 1 | Sleep enable bit of the write |
| cmd_type | input | TYPE_W | Sleep type code of the write |
| tmo_win | input | TMO_W | Stop-grant timeout window in cycles (0 acts as 1) |
| stpgnt_strb | input | 1 | One-cycle strobe from a decoded stop-grant bus cycle |
| wake | input | 1 | Wake request |
| stop_clk_n | output | 1 | Active-low stop-clock to the processors |
| stop_ctl | output | 1 | Stop-control output |
| plat_rst | output | 1 | Platform reset that gates downstream I/O |
| sts_state | output | 3 | Current state encoding |
| sts_err | output | 1 | Sticky stop-grant timeout flag |

## Verification
Two events can land on the same edge: the stop-grant strobe can arrive in the cycle in which the timeout window expires. The bench sweeps every window value from 0 to 7 against every strobe offset from 0 to 9. Each run therefore places the strobe before, exactly on, and after the last window cycle. From the offset and the window, the bench works out arithmetically whether the grant wins (state 2) or the timeout wins (state 0 with the error set), and it checks stray grant and start strobes in the stages that follow.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CLKWAIT = 3'd1,
    ST_STOPCTL = 3'd2,
    ST_RESET   = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_RESUME  = 3'd5
  } slp_state_e;
endpackage

// File: rtl/slp_cmd_decode.sv
module slp_cmd_decode #(
  parameter int TYPE_W = 3,
  parameter logic [TYPE_W-1:0] SUSP_CODE = 3'b101
) (
  input  logic              cmd_we,
  input  logic              cmd_en,
  input  logic [TYPE_W-1:0] cmd_type,
  output logic              start_req
);
  always_comb begin
    start_req = cmd_we && cmd_en && (cmd_type == SUSP_CODE);
  end
endmodule

// File: rtl/slp_timer.sv
module slp_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count + 1'b1;
  end
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_seq_pkg::*;
#(
  parameter int TMO_W     = 8,
  parameter int CNT_W     = 10,
  parameter int ENTRY_DLY = 8,
  parameter int WAKE_GAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             grant,
  input  logic             wake,
  input  logic [TMO_W-1:0] tmo_win,
  input  logic [CNT_W-1:0] count,
  output logic             tmr_clr,
  output slp_state_e       state,
  output logic             first_half,
  output logic             err
);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(ENTRY_DLY - 1);
  localparam logic [CNT_W-1:0] RES_LAST = CNT_W'(2 * WAKE_GAP - 1);
  localparam logic [CNT_W-1:0] GAP_LEN  = CNT_W'(WAKE_GAP);

  slp_state_e       nxt;
  logic             set_err, clr_err;
  logic [CNT_W-1:0] win_ext, win_last;

  always_comb begin
    win_ext  = {{(CNT_W-TMO_W){1'b0}}, tmo_win};
    win_last = (tmo_win == '0) ? '0 : win_ext - 1'b1;
  end

  always_comb begin
    nxt     = state;
    set_err = 1'b0;
    clr_err = 1'b0;
    case (state)
      ST_IDLE:    if (start_req) begin nxt = ST_CLKWAIT; clr_err = 1'b1; end
      ST_CLKWAIT: begin
        if (grant) nxt = ST_STOPCTL;
        else if (count == win_last) begin nxt = ST_IDLE; set_err = 1'b1; end
      end
      ST_STOPCTL: if (count == DLY_LAST) nxt = ST_RESET;
      ST_RESET:   nxt = ST_SLEEP;
      ST_SLEEP:   if (wake) nxt = ST_RESUME;
      ST_RESUME:  if (count == RES_LAST) nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_clr    = (nxt != state);
    first_half = (count < GAP_LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      if (set_err)      err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end
endmodule

// File: rtl/slp_pin_drive.sv
module slp_pin_drive
  import slp_seq_pkg::*;
(
  input  slp_state_e state,
  input  logic       first_half,
  output logic       stop_clk_n,
  output logic       stop_ctl,
  output logic       plat_rst
);
  always_comb begin
    stop_clk_n = (state == ST_IDLE);
    plat_rst   = (state == ST_RESET) || (state == ST_SLEEP);
    stop_ctl   = (state == ST_STOPCTL) || plat_rst ||
                 ((state == ST_RESUME) && first_half);
  end
endmodule

// File: rtl/slp_seq_top.sv
module slp_seq_top
  import slp_seq_pkg::*;
#(
  parameter int TYPE_W = 3,
  parameter logic [TYPE_W-1:0] SUSP_CODE = 3'b101,
  parameter int TMO_W     = 8,
  parameter int ENTRY_DLY = 8,
  parameter int WAKE_GAP  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              cmd_en,
  input  logic [TYPE_W-1:0] cmd_type,
  input  logic [TMO_W-1:0]  tmo_win,
  input  logic              stpgnt_strb,
  input  logic              wake,
  output logic              stop_clk_n,
  output logic              stop_ctl,
  output logic              plat_rst,
  output logic [2:0]        sts_state,
  output logic              sts_err
);
  localparam int LIM_A = (2 ** TMO_W > ENTRY_DLY) ? 2 ** TMO_W : ENTRY_DLY;
  localparam int LIM   = (LIM_A > 2 * WAKE_GAP) ? LIM_A : 2 * WAKE_GAP;
  localparam int CNT_W = $clog2(LIM + 1);

  logic             start_req, tmr_clr, first_half;
  logic [CNT_W-1:0] count;
  slp_state_e       state;

  slp_cmd_decode #(.TYPE_W(TYPE_W), .SUSP_CODE(SUSP_CODE)) u_dec (
    .cmd_we(cmd_we), .cmd_en(cmd_en), .cmd_type(cmd_type), .start_req(start_req)
  );

  slp_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .count(count)
  );

  slp_fsm #(.TMO_W(TMO_W), .CNT_W(CNT_W), .ENTRY_DLY(ENTRY_DLY),
            .WAKE_GAP(WAKE_GAP)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .grant(stpgnt_strb),
    .wake(wake), .tmo_win(tmo_win), .count(count), .tmr_clr(tmr_clr),
    .state(state), .first_half(first_half), .err(sts_err)
  );

  slp_pin_drive u_pins (
    .state(state), .first_half(first_half),
    .stop_clk_n(stop_clk_n), .stop_ctl(stop_ctl), .plat_rst(plat_rst)
  );

  always_comb sts_state = state;
endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk #(
  parameter int TYPE_W = 3,
  parameter logic [TYPE_W-1:0] SUSP_CODE = 3'b101,
  parameter int TMO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_we,
  input logic              cmd_en,
  input logic [TYPE_W-1:0] cmd_type,
  input logic [TMO_W-1:0]  tmo_win,
  input logic              stpgnt_strb,
  input logic              wake,
  input logic              stop_clk_n,
  input logic              stop_ctl,
  input logic              plat_rst,
  input logic [2:0]        sts_state,
  input logic              sts_err
);
  AST_START_STOPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_state == 3'd0 && cmd_we && cmd_en && cmd_type == SUSP_CODE) |=> !stop_clk_n); // R2

  AST_CTL_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_ctl) |-> $past(stpgnt_strb)); // R4

  AST_RST_AFTER_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plat_rst) |-> (stop_ctl && $past(stop_ctl))); // R5

  AST_TMO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_err) |-> (stop_clk_n && sts_state == 3'd0)); // R6

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_state == 3'd4 && !wake) |=> (sts_state == 3'd4)); // R7

  AST_CTL_FALL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_ctl) |-> !plat_rst); // R8

  AST_CLK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_clk_n) |-> (!stop_ctl && !plat_rst)); // R8

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_state <= 3'd5); // R9

  logic unused_ok;
  always_comb unused_ok = ^tmo_win;
endmodule

bind slp_seq_top slp_seq_chk #(.TYPE_W(TYPE_W), .SUSP_CODE(SUSP_CODE), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/slp_seq_top_test.sv
module slp_seq_top_test;
  localparam int DLY = 3;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 1'b0, cmd_en = 1'b0;
  logic [2:0] cmd_type = 3'd0;
  logic [2:0] tmo_win = 3'd0;
  logic stpgnt_strb = 1'b0, wake = 1'b0;
  logic stop_clk_n, stop_ctl, plat_rst, sts_err;
  logic [2:0] sts_state;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slp_seq_top #(.TYPE_W(3), .SUSP_CODE(3'b101), .TMO_W(3),
                .ENTRY_DLY(DLY), .WAKE_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_en(cmd_en),
    .cmd_type(cmd_type), .tmo_win(tmo_win), .stpgnt_strb(stpgnt_strb),
    .wake(wake), .stop_clk_n(stop_clk_n), .stop_ctl(stop_ctl),
    .plat_rst(plat_rst), .sts_state(sts_state), .sts_err(sts_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pins(string req, int st, int ckn, int ctl, int rst);
    chk({req, " state"}, sts_state, st);
    chk({req, " stop_clk_n"}, stop_clk_n, ckn);
    chk({req, " stop_ctl"}, stop_ctl, ctl);
    chk({req, " plat_rst"}, plat_rst, rst);
  endtask

  task automatic tick();
    @(negedge clk);
    cmd_we = 1'b0; stpgnt_strb = 1'b0; wake = 1'b0;
  endtask

  task automatic start_wr(logic en, logic [2:0] ty);
    cmd_we = 1'b1; cmd_en = en; cmd_type = ty;
  endtask

  task automatic run_case(int w, int off);
    int weff;
    bit won;
    weff = (w == 0) ? 1 : w;
    won = (off < weff);
    tmo_win = 3'(w);
    start_wr(1'b1, 3'b101);
    tick();
    pins("R2 start", 1, 0, 0, 0);
    chk("R2 err cleared", sts_err, 0);
    for (int c = 0; c < weff; c++) begin
      stpgnt_strb = (c == off);
      tick();
      if (c == off) begin
        pins("R4 grant", 2, 0, 1, 0);
        break;
      end else if (c == weff - 1) begin
        pins("R6 timeout", 0, 1, 0, 0);
        chk("R6 err", sts_err, 1);
      end else begin
        chk("R6 wait", sts_state, 1);
      end
    end
    if (!won) begin
      stpgnt_strb = 1'b1;
      tick();
      pins("R3 grant in idle", 0, 1, 0, 0);
      return;
    end
    for (int k = 0; k < DLY; k++) begin
      if (k == 0) begin stpgnt_strb = 1'b1; start_wr(1'b1, 3'b101); end
      pins("R5 ctl hold", 2, 0, 1, 0);
      tick();
    end
    pins("R5 reset", 3, 0, 1, 1);
    tick();
    pins("R5 sleep", 4, 0, 1, 1);
    for (int k = 0; k < 3; k++) begin
      stpgnt_strb = 1'b1;
      start_wr(1'b1, 3'b101);
      tick();
      pins("R7 hold", 4, 0, 1, 1);
    end
    wake = 1'b1;
    tick();
    for (int j = 0; j < 2 * GAP; j++) begin
      pins("R8 resume", 5, 0, (j < GAP) ? 1 : 0, 0);
      tick();
    end
    pins("R8 done", 0, 1, 0, 0);
    chk("R8 err", sts_err, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    pins("R1 reset", 0, 1, 0, 0);
    chk("R1 err", sts_err, 0);
    rst_n = 1'b1;
    tick();
    pins("R1 after release", 0, 1, 0, 0);
    start_wr(1'b0, 3'b101);
    tick();
    pins("R2 en low ignored", 0, 1, 0, 0);
    start_wr(1'b1, 3'b011);
    tick();
    pins("R2 wrong type ignored", 0, 1, 0, 0);
    wake = 1'b1;
    tick();
    pins("R7 wake in idle ignored", 0, 1, 0, 0);
    stpgnt_strb = 1'b1;
    tick();
    pins("R3 grant in idle ignored", 0, 1, 0, 0);
    tmo_win = 3'd4;
    start_wr(1'b1, 3'b101);
    tick();
    chk("R9 wait encoding", sts_state, 1);
    wake = 1'b1;
    tick();
    chk("R7 wake in wait ignored", sts_state, 1);
    for (int i = 0; i < 3; i++) tick();
    chk("R6 timeout err", sts_err, 1);
    for (int w = 0; w < 8; w++)
      for (int off = 0; off < 10; off++)
        run_case(w, off);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule